// File: doc/BRIEF.md
# Reference-Window Clock Frequency Meter

This block measures how fast one clock runs. It picks that clock from two banks of candidate sources: a bank of generated functional clocks and a bank of analog test clocks. It counts the clock's rising edges, optionally thinned by a programmable pre-divider, over a fixed window of a reference clock. Software programs a select word and a divider, arms the meter, then triggers it. It polls a busy bit until the bit clears and then reads a 16-bit edge count. Converting the count to kHz is left to software: count × f_ref / window × (divider + 1).

The block has three clock domains. The register port and its handshake logic run on the system clock. The window timer runs on the reference clock. The edge counter runs on whichever source is selected. The count crosses into the reference domain as a Gray code. The finished result returns to the register domain with a toggle handshake, so the result register only changes when a measurement completes. A source that is dead still lets the window close, and the measurement reports zero.

Top module: `clk_freq_meter`

## Requirements
- R1: With the mode field SEL[1:0] = 01, the meter counts the functional source whose index is in SEL[13:8].
- R2: With CFG[31:24] = N, one count is recorded per N+1 rising edges of the selected source, so N = 3 yields a quarter of the undivided count.
- R3: A completed measurement leaves in RES[15:0] the number of (divided) source edges seen during exactly WIN_CYCLES (default 1024) reference clock periods, within ±3.
- R4: With SEL[1:0] = 00, the meter counts the test source whose index is in SEL[21:16]. In this mode the functional index field has no effect.
- R5: Source index 0, and the mode codes 10 and 11, select no clock. Such a measurement completes with a count of 0.
- R6: A CTRL write with bit 12 (enable) and bit 4 (start) both set, made while enable is already 1 and the meter is idle, launches a measurement. CTRL bit 4 then reads 1 from the next cycle. It clears by itself when the count is valid.
- R7: A start write made while the enable bit was 0 launches nothing. CTRL bit 4 stays 0, and only the enable bit takes the written value.
- R8: The count saturates at 0xFFFF when more than 65535 edges fall inside the window.
- R9: A selected source that never toggles still lets the measurement finish at the end of the window, with a count of 0.
- R10: Writing 0 to CTRL clears enable and busy on the next cycle. The aborted run never updates RES.
- R11: After an abort, a fresh enable-then-start sequence runs a complete, correct measurement.
- R12: Registers sit at byte offsets SEL 0x0, CFG 0x4, CTRL 0x8 and RES 0xC. All read 0 after reset. Unimplemented bits read 0. RES changes only in the cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the register port |
| rst_n | input | 1 | Active-low reset, synchronised inside each domain |
| ref_clk | input | 1 | Reference clock that times the window |
| func_clk | input | NSRC | Functional candidate clocks; bit 0 is unused |
| test_clk | input | NSRC | Analog test candidate clocks; bit 0 is unused |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address; only word-aligned offsets decode |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The interesting same-cycle event is a software abort (a write of 0 to CTRL) landing on the clock edge where the completion toggle reaches the register domain. The write is given priority, so the capture is dropped. The bench first times a full run of a known source. It then repeats that run with a different count already in RES, and aborts at a sweep of cycle offsets around the expected completion. After every trial it requires CTRL to read 0 and RES to hold either the previous count or the count of the new source, never a mixture.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
// fm_pkg: register indices, field positions and state encodings shared by
// the frequency meter modules. Assumes 32-bit word-aligned registers.
package fm_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        RIDX_SEL  = 2'd0,
        RIDX_CFG  = 2'd1,
        RIDX_CTRL = 2'd2,
        RIDX_RES  = 2'd3
    } reg_idx_e;

    localparam int CTRL_EN_BIT  = 12;
    localparam int CTRL_GO_BIT  = 4;
    localparam int SEL_MODE_LSB = 0;
    localparam int SEL_FID_LSB  = 8;
    localparam int SEL_TID_LSB  = 16;
    localparam int CFG_DIV_LSB  = 24;

    localparam logic [1:0] MODE_TEST = 2'b00;
    localparam logic [1:0] MODE_FUNC = 2'b01;

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_COUNT = 2'd1,
        WIN_HOLD  = 2'd2
    } win_state_e;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
// fm_sync: multi-stage flip-flop synchroniser for a W-bit value.
// Assumes multi-bit inputs change at most one bit at a time (Gray code)
// or are levels. Tie rst_n high to use it as a reset synchroniser.
module fm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Purpose: shift the input through STAGES flops in the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fm_src_mux.sv
`timescale 1ns/1ps
// fm_src_mux: picks the clock to measure from two candidate banks.
// The mode selects the bank; index 0 of either bank and unknown modes
// give a constant low. Assumes selects are static during a measurement.
module fm_src_mux
    import fm_pkg::*;
#(
    parameter int NSRC = 64,
    localparam int ID_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] func_clk,
    input  logic [NSRC-1:0] test_clk,
    input  logic [1:0]      mode,
    input  logic [ID_W-1:0] fid,
    input  logic [ID_W-1:0] tid,
    output logic            meas_clk
);
    // Purpose: bank and index selection with the dummy index forced low.
    always_comb begin
        if (mode == MODE_FUNC)
            meas_clk = (fid != '0) & func_clk[fid];
        else if (mode == MODE_TEST)
            meas_clk = (tid != '0) & test_clk[tid];
        else
            meas_clk = 1'b0;
    end
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
// fm_edge_counter: free-running edge counter in the measured clock domain.
// A prescaler advances the count once per div+1 rising edges. The count is
// published as registered Gray code for sampling by the reference domain.
// Assumes div is static while a measurement runs. A source that stops
// leaves the Gray value frozen, which the window logic reads as zero edges.
module fm_edge_counter #(
    parameter int DIV_W = 8,
    parameter int RUN_W = 24
) (
    input  logic             meas_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic [RUN_W-1:0] gray_q
);
    logic             rst_m_n;
    logic [DIV_W-1:0] pre_q;
    logic [RUN_W-1:0] bin_q;

    fm_sync #(.W(1), .STAGES(2)) u_rst_sync (
        .clk(meas_clk), .rst_n(1'b1), .d(rst_n), .q(rst_m_n)
    );

    // Purpose: prescale the source edges and advance the binary count.
    always_ff @(posedge meas_clk) begin
        if (!rst_m_n) begin
            pre_q <= '0;
            bin_q <= '0;
        end else if (pre_q >= div) begin
            pre_q <= '0;
            bin_q <= bin_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Purpose: register the Gray form so that one bit changes per step.
    always_ff @(posedge meas_clk) begin
        if (!rst_m_n) gray_q <= '0;
        else          gray_q <= bin_q ^ (bin_q >> 1);
    end
endmodule

// File: rtl/fm_window.sv
`timescale 1ns/1ps
// fm_window: reference-domain window timer. When the synchronised run
// request rises, it snapshots the edge count, waits WIN_CYCLES reference
// periods, snapshots again, and publishes the saturated difference with a
// toggle. It holds until the request drops; dropping early aborts the run.
module fm_window
    import fm_pkg::*;
#(
    parameter int WIN_CYCLES = 1024,
    parameter int RUN_W      = 24,
    parameter int CNT_W      = 16,
    localparam int WIN_W     = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [RUN_W-1:0] gray_in,
    output logic             active,
    output logic             done_tgl,
    output logic [CNT_W-1:0] count
);
    logic             rst_r_n;
    logic             run_s;
    logic [RUN_W-1:0] gray_s;
    logic [RUN_W-1:0] cur_bin;
    logic [RUN_W-1:0] start_q;
    logic [RUN_W-1:0] diff;
    logic [WIN_W-1:0] win_q;
    win_state_e       state_q;

    fm_sync #(.W(1), .STAGES(2)) u_rst_sync (
        .clk(ref_clk), .rst_n(1'b1), .d(rst_n), .q(rst_r_n)
    );
    fm_sync #(.W(1), .STAGES(2)) u_run_sync (
        .clk(ref_clk), .rst_n(rst_r_n), .d(run_req), .q(run_s)
    );
    fm_sync #(.W(RUN_W), .STAGES(2)) u_gray_sync (
        .clk(ref_clk), .rst_n(rst_r_n), .d(gray_in), .q(gray_s)
    );

    // Purpose: convert the synchronised Gray count back to binary.
    always_comb begin
        cur_bin[RUN_W-1] = gray_s[RUN_W-1];
        for (int i = RUN_W - 2; i >= 0; i--) cur_bin[i] = cur_bin[i+1] ^ gray_s[i];
    end

    assign diff   = cur_bin - start_q;
    assign active = (state_q != WIN_IDLE);

    // Purpose: window sequencing, snapshot capture and result publication.
    always_ff @(posedge ref_clk) begin
        if (!rst_r_n) begin
            state_q  <= WIN_IDLE;
            start_q  <= '0;
            win_q    <= '0;
            done_tgl <= 1'b0;
            count    <= '0;
        end else begin
            case (state_q)
                WIN_IDLE: if (run_s) begin
                    start_q <= cur_bin;
                    win_q   <= '0;
                    state_q <= WIN_COUNT;
                end
                WIN_COUNT: begin
                    if (!run_s) begin
                        state_q <= WIN_IDLE;
                    end else if (win_q == WIN_W'(WIN_CYCLES - 1)) begin
                        count    <= (|diff[RUN_W-1:CNT_W]) ? '1 : diff[CNT_W-1:0];
                        done_tgl <= ~done_tgl;
                        state_q  <= WIN_HOLD;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                default: if (!run_s) state_q <= WIN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clk_freq_meter.sv
`timescale 1ns/1ps
// clk_freq_meter: top level of the reference-window frequency meter.
// Holds the register file on clk, steers one source into the edge counter,
// and runs the launch/abort/complete handshake with the window timer.
// Assumes SEL and CFG are not rewritten while a measurement is busy.
module clk_freq_meter
    import fm_pkg::*;
#(
    parameter int NSRC       = 64,
    parameter int DIV_W      = 8,
    parameter int CNT_W      = 16,
    parameter int RUN_W      = 24,
    parameter int WIN_CYCLES = 1024,
    parameter int ADDR_W     = 4,
    localparam int ID_W      = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic [NSRC-1:0]   func_clk,
    input  logic [NSRC-1:0]   test_clk,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [1:0]       mode_q;
    logic [ID_W-1:0]  fid_q;
    logic [ID_W-1:0]  tid_q;
    logic [DIV_W-1:0] div_q;
    logic             en_q;
    logic             busy_q;
    logic [CNT_W-1:0] result_q;
    logic             tgl_q;

    logic             meas_clk;
    logic [RUN_W-1:0] gray_w;
    logic             win_active;
    logic             win_tgl;
    logic [CNT_W-1:0] win_count;
    logic             tgl_s;
    logic             act_s;

    logic             aligned;
    reg_idx_e         ridx;
    logic             wr_sel, wr_cfg, wr_ctrl;
    logic             done_evt;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign ridx     = reg_idx_e'(bus_addr[3:2]);
    assign wr_sel   = bus_we && aligned && (ridx == RIDX_SEL);
    assign wr_cfg   = bus_we && aligned && (ridx == RIDX_CFG);
    assign wr_ctrl  = bus_we && aligned && (ridx == RIDX_CTRL);
    assign done_evt = tgl_s ^ tgl_q;

    fm_src_mux #(.NSRC(NSRC)) u_mux (
        .func_clk(func_clk), .test_clk(test_clk), .mode(mode_q),
        .fid(fid_q), .tid(tid_q), .meas_clk(meas_clk)
    );

    fm_edge_counter #(.DIV_W(DIV_W), .RUN_W(RUN_W)) u_cnt (
        .meas_clk(meas_clk), .rst_n(rst_n), .div(div_q), .gray_q(gray_w)
    );

    fm_window #(.WIN_CYCLES(WIN_CYCLES), .RUN_W(RUN_W), .CNT_W(CNT_W)) u_win (
        .ref_clk(ref_clk), .rst_n(rst_n), .run_req(busy_q), .gray_in(gray_w),
        .active(win_active), .done_tgl(win_tgl), .count(win_count)
    );

    fm_sync #(.W(1), .STAGES(2)) u_tgl_sync (
        .clk(clk), .rst_n(rst_n), .d(win_tgl), .q(tgl_s)
    );
    fm_sync #(.W(1), .STAGES(2)) u_act_sync (
        .clk(clk), .rst_n(rst_n), .d(win_active), .q(act_s)
    );

    // Purpose: source select and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            fid_q  <= '0;
            tid_q  <= '0;
            div_q  <= '0;
        end else begin
            if (wr_sel) begin
                mode_q <= bus_wdata[SEL_MODE_LSB +: 2];
                fid_q  <= bus_wdata[SEL_FID_LSB +: ID_W];
                tid_q  <= bus_wdata[SEL_TID_LSB +: ID_W];
            end
            if (wr_cfg) div_q <= bus_wdata[CFG_DIV_LSB +: DIV_W];
        end
    end

    // Purpose: enable/launch/abort control with the write taking priority
    // over a completion arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            busy_q   <= 1'b0;
            result_q <= '0;
            tgl_q    <= 1'b0;
        end else begin
            tgl_q <= tgl_s;
            if (wr_ctrl) begin
                en_q <= bus_wdata[CTRL_EN_BIT];
                if (!bus_wdata[CTRL_EN_BIT])
                    busy_q <= 1'b0;
                else if (bus_wdata[CTRL_GO_BIT] && en_q && !busy_q && !act_s)
                    busy_q <= 1'b1;
            end else if (done_evt && busy_q) begin
                result_q <= win_count;
                busy_q   <= 1'b0;
            end
        end
    end

    // Purpose: read multiplexer; unimplemented bits and offsets read 0.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (ridx)
                RIDX_SEL: begin
                    bus_rdata[SEL_MODE_LSB +: 2]  = mode_q;
                    bus_rdata[SEL_FID_LSB +: ID_W] = fid_q;
                    bus_rdata[SEL_TID_LSB +: ID_W] = tid_q;
                end
                RIDX_CFG:  bus_rdata[CFG_DIV_LSB +: DIV_W] = div_q;
                RIDX_CTRL: begin
                    bus_rdata[CTRL_EN_BIT] = en_q;
                    bus_rdata[CTRL_GO_BIT] = busy_q;
                end
                default:   bus_rdata[CNT_W-1:0] = result_q;
            endcase
        end
    end
endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
// fm_checker: protocol properties of the register-side handshake,
// attached to clk_freq_meter by the bind below.
module fm_checker
    import fm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic              en,
    input logic [CNT_W-1:0]  result
);
    logic ctrl_wr;
    assign ctrl_wr = bus_we && (bus_addr[1:0] == 2'b00) &&
                     (bus_addr[3:2] == RIDX_CTRL);

    // R6: busy only rises after a CTRL write carrying enable and start
    assert_launch_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_wr && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_GO_BIT]));

    // R7: a launch needs enable to have been set beforehand
    assert_enable_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en));

    // R10: writing zero disarms on the next cycle
    assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == '0) |=> (!busy && !en));

    // R12: the result register moves only together with busy falling
    assert_result_atomic_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));
endmodule

bind clk_freq_meter fm_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fm_checker (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy_q), .en(en_q), .result(result_q)
);

// File: tb/tb_clk_freq_meter.sv
`timescale 1ns/1ps
module tb_clk_freq_meter;
    localparam logic [3:0] A_SEL = 4'h0, A_CFG = 4'h4, A_CTRL = 4'h8, A_RES = 4'hC;

    typedef struct packed {
        logic [1:0]  mode;
        logic [5:0]  fid;
        logic [5:0]  tid;
        logic [7:0]  div;
        logic [16:0] expv;
        logic [3:0]  tol;
    } vec_t;

    // window = 1024 x 38 ns = 38912 ns
    localparam vec_t VECS [10] = '{
        '{2'b01, 6'd5,  6'd0, 8'd0, 17'd3891,  4'd3},  // R1 R3: 10 ns source
        '{2'b01, 6'd5,  6'd0, 8'd3, 17'd973,   4'd3},  // R2: divide by 4
        '{2'b01, 6'd63, 6'd0, 8'd0, 17'd9728,  4'd3},  // R1: 4 ns source
        '{2'b00, 6'd5,  6'd7, 8'd0, 17'd2432,  4'd3},  // R4: test bank 16 ns
        '{2'b00, 6'd63, 6'd1, 8'd1, 17'd486,   4'd3},  // R4 R2: 40 ns, div 2
        '{2'b01, 6'd2,  6'd0, 8'd0, 17'd65535, 4'd0},  // R8: 0.5 ns source
        '{2'b01, 6'd9,  6'd0, 8'd0, 17'd0,     4'd0},  // R9: dead source
        '{2'b01, 6'd0,  6'd7, 8'd0, 17'd0,     4'd0},  // R5: dummy index
        '{2'b10, 6'd5,  6'd7, 8'd0, 17'd0,     4'd0},  // R5: mode 10
        '{2'b11, 6'd5,  6'd7, 8'd0, 17'd0,     4'd0}   // R5: mode 11
    };

    logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
    logic f2 = 1'b0, f5 = 1'b0, f63 = 1'b0, t1 = 1'b0, t7 = 1'b0;
    logic f9 = 1'b0;
    logic fast_on = 1'b0;
    logic [63:0] func_clk, test_clk;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #4    clk = ~clk;
    always #19   ref_clk = ~ref_clk;
    always #5    f5  = ~f5;
    always #2    f63 = ~f63;
    always #20   t1  = ~t1;
    always #8    t7  = ~t7;
    always begin
        wait (fast_on);
        #0.25 f2 = ~f2;
    end

    assign func_clk = {f63, 53'b0, f9, 3'b0, f5, 2'b0, f2, 2'b0};
    assign test_clk = {56'b0, t7, 5'b0, t1, 1'b0};

    clk_freq_meter dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .func_clk(func_clk), .test_clk(test_clk),
        .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, expv, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic start_meas(input logic [31:0] sel, input logic [31:0] cfg, input string tag);
        logic [31:0] c;
        repeat (30) @(negedge clk);
        wr(A_SEL, sel);
        wr(A_CFG, cfg);
        wr(A_CTRL, 32'h0000_1000);
        wr(A_CTRL, 32'h0000_1010);
        rd(A_CTRL, c);
        check(c == 32'h0000_1010, {tag, " R6 busy after start"}, c, 32'h1010);
    endtask

    task automatic wait_done(input string tag, output int cyc);
        logic [31:0] c;
        cyc = 0;
        c = 32'h10;
        while (c[4] && cyc < 8000) begin
            rd(A_CTRL, c);
            cyc++;
        end
        check(!c[4], {tag, " R6 busy self-clears"}, c[4], 0);
    endtask

    function automatic logic [31:0] sel_word(input logic [1:0] m, input logic [5:0] fi, input logic [5:0] ti);
        return {10'b0, ti, 2'b0, fi, 6'b0, m};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R6 watchdog: got %0d cycles expected fewer", 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, prev;
        int cyc, t_full;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: reset values
        rd(A_SEL, r);  check(r == 0, "R12 SEL reset", r, 0);
        rd(A_CFG, r);  check(r == 0, "R12 CFG reset", r, 0);
        rd(A_CTRL, r); check(r == 0, "R12 CTRL reset", r, 0);
        rd(A_RES, r);  check(r == 0, "R12 RES reset", r, 0);

        // R12: unimplemented bits read 0
        wr(A_SEL, 32'hFFFF_FFFF); rd(A_SEL, r);
        check(r == 32'h003F_3F03, "R12 SEL readback", r, 32'h003F3F03);
        wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, r);
        check(r == 32'hFF00_0000, "R12 CFG readback", r, 32'hFF000000);
        wr(A_CFG, 32'h0);

        // R7: start without enable first
        wr(A_SEL, sel_word(2'b01, 6'd5, 6'd0));
        wr(A_CTRL, 32'h0000_1010);
        rd(A_CTRL, r);
        check(r == 32'h0000_1000, "R7 start ignored without prior enable", r, 32'h1000);
        repeat (3) @(negedge clk);
        rd(A_CTRL, r);
        check(r[4] == 1'b0, "R7 still idle", r[4], 0);
        wr(A_CTRL, 32'h0);

        // Vector table: R1 R2 R3 R4 R5 R8 R9
        for (int i = 0; i < 10; i++) begin
            vec_t v;
            string tag;
            longint lo, hi;
            v = VECS[i];
            if (v.expv == 17'd65535)                tag = "R8 saturation";
            else if (v.fid == 6'd9)                 tag = "R9 dead source";
            else if (v.expv == 0)                   tag = "R5 no source";
            else if (v.mode == 2'b00)               tag = "R4 test bank";
            else if (v.div != 0)                    tag = "R2 prescale";
            else                                    tag = "R1 R3 functional";
            fast_on = (v.mode == 2'b01) && (v.fid == 6'd2);
            start_meas(sel_word(v.mode, v.fid, v.tid), {v.div, 24'b0}, tag);
            wait_done(tag, cyc);
            rd(A_RES, r);
            lo = longint'(v.expv) - longint'(v.tol);
            hi = longint'(v.expv) + longint'(v.tol);
            check((longint'(r) >= lo) && (longint'(r) <= hi), {tag, " count"}, r, v.expv);
            fast_on = 1'b0;
            wr(A_CTRL, 32'h0);
        end

        // R10: abort mid-window leaves the old result
        rd(A_RES, prev);
        start_meas(sel_word(2'b01, 6'd63, 6'd0), 32'h0, "R10");
        repeat (200) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, r);
        check(r == 0, "R10 disarm clears CTRL", r, 0);
        repeat (5500) @(negedge clk);
        rd(A_RES, r);
        check(r == prev, "R10 aborted run leaves RES", r, prev);

        // R11: re-trigger after abort
        start_meas(sel_word(2'b01, 6'd5, 6'd0), 32'h0, "R11");
        wait_done("R11", t_full);
        rd(A_RES, r);
        check(r >= 3888 && r <= 3894, "R11 re-trigger count", r, 3891);
        wr(A_CTRL, 32'h0);

        // R12 R10: abort colliding with completion
        for (int off = -3; off <= 2; off++) begin
            start_meas(sel_word(2'b01, 6'd63, 6'd0), 32'h0, "R12 seed");
            wait_done("R12 seed", cyc);
            wr(A_CTRL, 32'h0);
            rd(A_RES, prev);
            start_meas(sel_word(2'b01, 6'd5, 6'd0), 32'h0, "R12 sweep");
            repeat (t_full + off) @(negedge clk);
            wr(A_CTRL, 32'h0);
            repeat (40) @(negedge clk);
            rd(A_CTRL, r);
            check(r == 0, "R10 CTRL after collision", r, 0);
            rd(A_RES, r);
            check((r == prev) || (r >= 3888 && r <= 3894), "R12 RES old or whole new", r, 3891);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule